// File: doc/BRIEF.md
# Shadow Region Attribute Decoder

This block sits beside the memory controller of a host bridge and keeps the control bytes that decide where accesses to the upper part of the first megabyte go. Each clock, the block takes a 20-bit lookup address. One cycle later it reports three things:

- whether a read at that address is served from internal DRAM or from the external bus;
- whether a write at that address goes to DRAM, is dropped, or goes to the external bus;
- whether the address falls inside the enabled SMRAM window.

The option-ROM area from C0000h to DFFFFh is split into eight 16 KB segments. One bitmap byte controls them, one bit per segment. The two 64 KB segments at E0000h and F0000h each take a 2-bit code from a second control byte. A third byte carries the enable for a 64 KB SMRAM window based at E0000h.

Firmware programs the bytes through a byte-wide configuration write port at their bus offsets. A registered read port returns them, along with a fixed host-bridge identity header.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After a synchronous reset, every control byte reads 0. Every shadowed segment from C0000h to FFFFFh therefore reports an external read and an external write. The lookup outputs hold DRAM read, DRAM write and no SMRAM hit while reset is held.
- R2: The lookup outputs are registered. The address applied before clock edge k is reflected on the outputs after edge k, using the control bytes held before that edge.
- R3: A region code with bit 0 clear gives look_rd_dram = 0 (external read) and look_wr_tgt = 2'b00 (external write).
- R4: A region code with bit 0 set gives look_rd_dram = 1. When bit 1 is also set, look_wr_tgt = 2'b10 (write dropped). When bit 1 is clear, look_wr_tgt = 2'b01 (DRAM write).
- R5: The region code of E0000h–EFFFFh is bits 3:2 of the byte at offset 0x5F. The region code of F0000h–FFFFFh is bits 7:6 of the same byte.
- R6: Bit i of the byte at offset 0x5D governs the 16 KB segment starting at C0000h + i·4000h, for i = 0 to 7. A set bit gives DRAM read and DRAM write. A clear bit gives external read and external write.
- R7: look_smm_hit is 1 exactly when bit 4 of the byte at offset 0x65 is set and the address lies in E0000h–EFFFFh.
- R8: Addresses below C0000h always report DRAM read, DRAM write and no SMRAM hit, whatever the control bytes hold.
- R9: A control byte written at clock edge k governs lookups sampled at edge k+1 and later. A lookup sampled at edge k still sees the old value.
- R10: cfg_rd_data returns, one edge after cfg_rd_addr is applied, the following values:
  - at 0x08: 0x01;
  - at 0x09: 0x00;
  - at 0x0A: 0x00;
  - at 0x0B: 0x06;
  - at 0x5C, 0x5D, 0x5E, 0x5F and 0x65: the last byte written there;
  - at every other offset: 0.

  Writes to the header and to unlisted offsets are ignored. The bytes at 0x5C and 0x5E are stored but do not change any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | 8 | Configuration write offset |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_addr | input | 8 | Configuration read offset |
| cfg_rd_data | output | 8 | Registered configuration read data |
| look_addr | input | 20 | Lookup address |
| look_rd_dram | output | 1 | 1: read from DRAM, 0: read from external bus |
| look_wr_tgt | output | 2 | 00 external, 01 DRAM, 10 dropped |
| look_smm_hit | output | 1 | Address inside the enabled SMRAM window |

## Verification
A wrong stored control byte, or a wrong segment index, shows up on the lookup outputs at the very next edge after an address in the affected segment is applied. The bench therefore sweeps the first and last byte of every segment after each control change, so a corrupted bit appears within one cycle of the sweep reaching that segment. A stale or early update of the control bytes shows up as a mismatch on the lookup issued in the same cycle as the write. Errors in storage or address decode of the configuration bytes appear on cfg_rd_data one edge after the read offset is applied.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;

  typedef enum logic [1:0] {
    WR_EXT   = 2'b00,
    WR_DRAM  = 2'b01,
    WR_BLOCK = 2'b10
  } wr_tgt_e;

  typedef struct packed {
    logic    rd_dram;
    wr_tgt_e wr;
  } attr_t;

  localparam logic [7:0] HDR_REV_VAL   = 8'h01;
  localparam logic [7:0] HDR_PIF_VAL   = 8'h00;
  localparam logic [7:0] HDR_SUB_VAL   = 8'h00;
  localparam logic [7:0] HDR_CLASS_VAL = 8'h06;

  localparam attr_t ATTR_PLAIN_DRAM = '{rd_dram: 1'b1, wr: WR_DRAM};

  // bit 0 steers both directions to DRAM, bit 1 then drops writes
  function automatic attr_t code_to_attr(input logic [1:0] code);
    attr_t a;
    if (!code[0]) begin
      a.rd_dram = 1'b0;
      a.wr      = WR_EXT;
    end else begin
      a.rd_dram = 1'b1;
      a.wr      = code[1] ? WR_BLOCK : WR_DRAM;
    end
    return a;
  endfunction

endpackage

// File: rtl/shadow_ctrl_regs.sv
module shadow_ctrl_regs
  import shadow_dec_pkg::*;
#(
  parameter int          REG_AW      = 8,
  parameter int          NUM_ROM_SEG = 8,
  parameter logic [7:0]  OFS_AUX_LO  = 8'h5C,
  parameter logic [7:0]  OFS_ROM_MAP = 8'h5D,
  parameter logic [7:0]  OFS_AUX_HI  = 8'h5E,
  parameter logic [7:0]  OFS_HI_CTL  = 8'h5F,
  parameter logic [7:0]  OFS_SMM_CTL = 8'h65,
  parameter int          E_CODE_LSB  = 2,
  parameter int          F_CODE_LSB  = 6,
  parameter int          SMM_EN_BIT  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [REG_AW-1:0]      rd_addr,
  output logic [7:0]             rd_data,
  output logic [NUM_ROM_SEG-1:0] rom_map,
  output logic [1:0]             e_code,
  output logic [1:0]             f_code,
  output logic                   smm_en
);

  localparam int NUM_CTRL = 5;
  localparam logic [NUM_CTRL*8-1:0] OFS_LIST =
    {OFS_SMM_CTL, OFS_HI_CTL, OFS_AUX_HI, OFS_ROM_MAP, OFS_AUX_LO};
  localparam int IDX_ROM = 1;
  localparam int IDX_HI  = 3;
  localparam int IDX_SMM = 4;

  logic [7:0] ctrl_q [NUM_CTRL];
  logic [NUM_CTRL-1:0] rd_hit;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst)
        ctrl_q[g] <= '0;
      else if (wr_en && (wr_addr == REG_AW'(OFS_LIST[g*8 +: 8])))
        ctrl_q[g] <= wr_data;
    end
    assign rd_hit[g] = (rd_addr == REG_AW'(OFS_LIST[g*8 +: 8]));
  end

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      REG_AW'(8'h08): rd_mux = HDR_REV_VAL;
      REG_AW'(8'h09): rd_mux = HDR_PIF_VAL;
      REG_AW'(8'h0A): rd_mux = HDR_SUB_VAL;
      REG_AW'(8'h0B): rd_mux = HDR_CLASS_VAL;
      default: begin
        for (int i = 0; i < NUM_CTRL; i++)
          if (rd_hit[i]) rd_mux = ctrl_q[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign rom_map = ctrl_q[IDX_ROM][NUM_ROM_SEG-1:0];
  assign e_code  = ctrl_q[IDX_HI][E_CODE_LSB +: 2];
  assign f_code  = ctrl_q[IDX_HI][F_CODE_LSB +: 2];
  assign smm_en  = ctrl_q[IDX_SMM][SMM_EN_BIT];

endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_dec_pkg::*;
#(
  parameter int                ADDR_W      = 20,
  parameter int                NUM_ROM_SEG = 8,
  parameter int                ROM_SEG_W   = 14,
  parameter int                HI_SEG_W    = 16,
  parameter int                SMM_W       = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE    = 20'hC0000,
  parameter logic [ADDR_W-1:0] HI_BASE     = 20'hE0000,
  parameter logic [ADDR_W-1:0] SMM_BASE    = 20'hE0000
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NUM_ROM_SEG-1:0] rom_map,
  input  logic [1:0]             e_code,
  input  logic [1:0]             f_code,
  input  logic                   smm_en,
  output attr_t                  attr,
  output logic                   smm_hit
);

  localparam int IDX_W = (NUM_ROM_SEG > 1) ? $clog2(NUM_ROM_SEG) : 1;
  localparam logic [ADDR_W:0] ROM_END = {1'b0, ROM_BASE} + ((ADDR_W+1)'(NUM_ROM_SEG) << ROM_SEG_W);
  localparam logic [ADDR_W:0] HI_END  = {1'b0, HI_BASE} + ((ADDR_W+1)'(2) << HI_SEG_W);
  localparam logic [ADDR_W:0] SMM_END = {1'b0, SMM_BASE} + ((ADDR_W+1)'(1) << SMM_W);

  logic [1:0] rom_code [NUM_ROM_SEG];
  for (genvar g = 0; g < NUM_ROM_SEG; g++) begin : g_rom
    assign rom_code[g] = {1'b0, rom_map[g]};
  end

  logic [ADDR_W:0]  a_ext;
  logic             in_rom, in_hi, hi_sel;
  logic [IDX_W-1:0] rom_idx;

  assign a_ext   = {1'b0, addr};
  assign in_rom  = (a_ext >= {1'b0, ROM_BASE}) && (a_ext < ROM_END);
  assign in_hi   = (a_ext >= {1'b0, HI_BASE})  && (a_ext < HI_END);
  assign rom_idx = IDX_W'((addr - ROM_BASE) >> ROM_SEG_W);
  assign hi_sel  = 1'((addr - HI_BASE) >> HI_SEG_W);

  always_comb begin
    if (in_rom)     attr = code_to_attr(rom_code[rom_idx]);
    else if (in_hi) attr = code_to_attr(hi_sel ? f_code : e_code);
    else            attr = ATTR_PLAIN_DRAM;
  end

  assign smm_hit = smm_en && (a_ext >= {1'b0, SMM_BASE}) && (a_ext < SMM_END);

endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int REG_AW      = 8,
  parameter int NUM_ROM_SEG = 8,
  parameter int ROM_SEG_W   = 14,
  parameter int HI_SEG_W    = 16,
  parameter int SMM_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [REG_AW-1:0] cfg_wr_addr,
  input  logic [7:0]        cfg_wr_data,
  input  logic [REG_AW-1:0] cfg_rd_addr,
  output logic [7:0]        cfg_rd_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_rd_dram,
  output logic [1:0]        look_wr_tgt,
  output logic              look_smm_hit
);

  logic [NUM_ROM_SEG-1:0] rom_map;
  logic [1:0]             e_code, f_code;
  logic                   smm_en;
  attr_t                  attr_d;
  logic                   smm_d;

  shadow_ctrl_regs #(
    .REG_AW      (REG_AW),
    .NUM_ROM_SEG (NUM_ROM_SEG)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .rd_addr (cfg_rd_addr),
    .rd_data (cfg_rd_data),
    .rom_map (rom_map),
    .e_code  (e_code),
    .f_code  (f_code),
    .smm_en  (smm_en)
  );

  shadow_seg_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_ROM_SEG (NUM_ROM_SEG),
    .ROM_SEG_W   (ROM_SEG_W),
    .HI_SEG_W    (HI_SEG_W),
    .SMM_W       (SMM_W)
  ) u_dec (
    .addr    (look_addr),
    .rom_map (rom_map),
    .e_code  (e_code),
    .f_code  (f_code),
    .smm_en  (smm_en),
    .attr    (attr_d),
    .smm_hit (smm_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      look_rd_dram <= 1'b1;
      look_wr_tgt  <= WR_DRAM;
      look_smm_hit <= 1'b0;
    end else begin
      look_rd_dram <= attr_d.rd_dram;
      look_wr_tgt  <= attr_d.wr;
      look_smm_hit <= smm_d;
    end
  end

endmodule

// File: rtl/shadow_attr_decoder_chk.sv
module shadow_attr_decoder_chk #(
  parameter int ADDR_W = 20,
  parameter int REG_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] cfg_rd_addr,
  input logic [7:0]        cfg_rd_data,
  input logic [ADDR_W-1:0] look_addr,
  input logic              look_rd_dram,
  input logic [1:0]        look_wr_tgt,
  input logic              look_smm_hit
);

  // R3
  ext_read_ext_write_chk: assert property (@(posedge clk) disable iff (rst)
    !look_rd_dram |-> (look_wr_tgt == 2'b00));

  // R8
  low_area_dram_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(look_addr) < ADDR_W'(20'hC0000)) |->
      (look_rd_dram && look_wr_tgt == 2'b01 && !look_smm_hit));

  // R7
  smm_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    look_smm_hit |-> ($past(look_addr) >= ADDR_W'(20'hE0000) &&
                      $past(look_addr) <= ADDR_W'(20'hEFFFF)));

  // R4
  drop_only_high_chk: assert property (@(posedge clk) disable iff (rst)
    (look_wr_tgt == 2'b10) |-> ($past(look_addr) >= ADDR_W'(20'hE0000)));

  // R10
  class_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_rd_addr) == REG_AW'(8'h0B)) |-> (cfg_rd_data == 8'h06));

endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk #(
  .ADDR_W (ADDR_W),
  .REG_AW (REG_AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_rd_addr  (cfg_rd_addr),
  .cfg_rd_data  (cfg_rd_data),
  .look_addr    (look_addr),
  .look_rd_dram (look_rd_dram),
  .look_wr_tgt  (look_wr_tgt),
  .look_smm_hit (look_smm_hit)
);

// File: tb/shadow_attr_decoder_tb.sv
module shadow_attr_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic [7:0]  cfg_rd_addr = '0;
  logic [7:0]  cfg_rd_data;
  logic [19:0] look_addr = '0;
  logic        look_rd_dram;
  logic [1:0]  look_wr_tgt;
  logic        look_smm_hit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // behavioural model state
  int m_cfg [256];

  always #4 clk = ~clk;

  shadow_attr_decoder u_dut (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_addr  (cfg_wr_addr),
    .cfg_wr_data  (cfg_wr_data),
    .cfg_rd_addr  (cfg_rd_addr),
    .cfg_rd_data  (cfg_rd_data),
    .look_addr    (look_addr),
    .look_rd_dram (look_rd_dram),
    .look_wr_tgt  (look_wr_tgt),
    .look_smm_hit (look_smm_hit)
  );

  function automatic bit is_ctrl(int a);
    return (a == 'h5C || a == 'h5D || a == 'h5E || a == 'h5F || a == 'h65);
  endfunction

  function automatic int m_read(int a);
    if (a == 'h08) return 1;
    if (a == 'h0B) return 6;
    if (is_ctrl(a)) return m_cfg[a];
    return 0;
  endfunction

  // region code for an address; -1 means plain DRAM area
  function automatic int m_code(int a);
    if (a < 'hC0000) return -1;
    if (a < 'hE0000) return (m_cfg['h5D] >> ((a - 'hC0000) / 'h4000)) % 2;
    if (a < 'hF0000) return (m_cfg['h5F] / 4) % 4;
    return (m_cfg['h5F] / 64) % 4;
  endfunction

  function automatic int m_rd(int a);
    int c = m_code(a);
    if (c < 0) return 1;
    return c % 2;
  endfunction

  function automatic int m_wr(int a);
    int c = m_code(a);
    if (c < 0) return 1;
    if (c % 2 == 0) return 0;
    return (c >= 2) ? 2 : 1;
  endfunction

  function automatic int m_smm(int a);
    return ((m_cfg['h65] / 16) % 2 == 1 && a >= 'hE0000 && a < 'hF0000) ? 1 : 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(bit we, int wa, int wd, int la, int ra, string req);
    int e_rd, e_wr, e_sm, e_dat;
    cfg_wr_en   = we;
    cfg_wr_addr = wa[7:0];
    cfg_wr_data = wd[7:0];
    look_addr   = la[19:0];
    cfg_rd_addr = ra[7:0];
    e_rd  = m_rd(la);
    e_wr  = m_wr(la);
    e_sm  = m_smm(la);
    e_dat = m_read(ra);
    if (we && is_ctrl(wa)) m_cfg[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check(req, "rd_dram", int'(look_rd_dram), e_rd);
    check(req, "wr_tgt",  int'(look_wr_tgt),  e_wr);
    check(req, "smm_hit", int'(look_smm_hit), e_sm);
    check(req, "rd_data", int'(cfg_rd_data),  e_dat);
  endtask

  task automatic look(int la, string req);
    cyc(1'b0, 0, 0, la, 'h5F, req);
  endtask

  task automatic wr(int wa, int wd, string req);
    cyc(1'b1, wa, wd, 0, wa, req);
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < 8; s++) begin
      look('hC0000 + s * 'h4000, req);
      look('hC3FFF + s * 'h4000, req);
    end
    look('hE0000, req); look('hEFFFF, req);
    look('hF0000, req); look('hFFFFF, req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_cfg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values on outputs
    check("R1", "rd_dram", int'(look_rd_dram), 1);
    check("R1", "wr_tgt",  int'(look_wr_tgt),  1);
    check("R1", "smm_hit", int'(look_smm_hit), 0);
    check("R1", "rd_data", int'(cfg_rd_data),  0);
    rst = 1'b0;

    // R1: control bytes zero, shadow area external
    cyc(1'b0, 0, 0, 'hE0000, 'h5D, "R1");
    cyc(1'b0, 0, 0, 'hC0000, 'h65, "R1");
    sweep("R1");

    // R10 header and read-only behaviour
    for (int h = 'h00; h < 'h10; h++) cyc(1'b0, 0, 0, 0, h, "R10");
    wr('h0B, 'hFF, "R10"); look(0, "R10"); cyc(1'b0, 0, 0, 0, 'h0B, "R10");
    wr('h30, 'h55, "R10"); cyc(1'b0, 0, 0, 0, 'h30, "R10");

    // R6 bitmap segments, R2 latency exercised by every cycle
    wr('h5D, 'hA5, "R6"); sweep("R6");
    wr('h5D, 'h5A, "R6"); sweep("R6");

    // R3 R4 R5 every code on E and F
    for (int c = 0; c < 16; c++) begin
      wr('h5F, (c % 4) * 4 + (c / 4) * 64, "R5");
      look('hE0000, "R4"); look('hEFFFF, "R3");
      look('hF0000, "R5"); look('hFFFFF, "R4");
    end

    // R8 low area
    wr('h5F, 'hFF, "R8"); wr('h5D, 'h00, "R8");
    look('h00000, "R8"); look('h9FFFF, "R8"); look('hBFFFF, "R8");

    // R7 SMRAM window
    wr('h65, 'h10, "R7");
    look('hE8000, "R7"); look('hEFFFF, "R7"); look('hF0000, "R7");
    look('hDFFFF, "R7"); look('h00000, "R7");
    wr('h65, 'hEF, "R7"); look('hE0000, "R7");

    // R9 write and lookup in the same cycle
    cyc(1'b1, 'h5D, 'hFF, 'hC4000, 'h5D, "R9");
    look('hC4000, "R9");
    cyc(1'b1, 'h5F, 'h00, 'hF8000, 'h5F, "R9");
    look('hF8000, "R9");

    // R10 aux bytes stored but without effect
    wr('h5C, 'h3C, "R10"); wr('h5E, 'hC3, "R10");
    cyc(1'b0, 0, 0, 'hC0000, 'h5C, "R10");
    cyc(1'b0, 0, 0, 'hE0000, 'h5E, "R10");
    sweep("R10");

    // R1 reset again clears control bytes
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) m_cfg[i] = 0;
    cyc(1'b0, 0, 0, 'hC4000, 'h5D, "R1");
    cyc(1'b0, 0, 0, 'hE0000, 'h65, "R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule